// File: doc/BRIEF.md
# Cascadable presettable binary counter

A synchronous up-counter of parameterised width (four bits by default) that advances on the rising clock edge. An active-low clear zeroes the count at once, without waiting for a clock. An active-low load copies a data word into the count on the next edge. Two active-high enables must both be high for the counter to advance.

Only one of the two enables, the carry enable, also gates the terminal-count flag. The flag is high when that enable is high and the count is all ones. The flag changes combinationally with the carry enable and does not wait for a clock. Several stages chain into a wider counter: each stage's flag drives the next stage's carry enable, and all stages share the clock, clear, load and the other enable. Load takes priority over both enables. Clear takes priority over everything else.

Top module: `casc_counter`

## Requirements
- R1: While `clr_n` is 0, `count` is all zeros at once, with no clock edge, whatever `clk`, `load_n`, `en_par` and `en_carry` do.
- R2: At a rising edge with `clr_n` = 1 and `load_n` = 0, `count` takes the value of `din`, for every combination of `en_par` and `en_carry`.
- R3: At a rising edge with `clr_n` = 1, `load_n` = 1, `en_par` = 1 and `en_carry` = 1, `count` increases by one.
- R4: At a rising edge with `clr_n` = 1, `load_n` = 1 and `en_par` or `en_carry` (or both) at 0, `count` keeps its value.
- R5: `tc` is 1 exactly when `en_carry` is 1 and `count` is all ones. It is 0 while `clr_n` is 0.
- R6: `tc` follows a change of `en_carry` within the same clock period, with no clock edge in between.
- R7: Counting from all ones gives all zeros (wrap-around).
- R8: Apart from the clear, `count` changes only at rising edges. After `clr_n` returns to 1, the first rising edge applies load, count or hold as normal.
- R9: Two stages, where the low stage's `tc` drives the high stage's `en_carry` and both share `load_n` and `en_par`, form an 8-bit counter that carries from 0x0F to 0x10 and from 0xFF to 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| en_par | input | 1 | Count enable that does not reach the flag |
| en_carry | input | 1 | Count enable that also gates `tc` |
| din | input | WIDTH | Value to load |
| count | output | WIDTH | Current count |
| tc | output | 1 | Terminal-count flag |

## Verification
The bench uses the default width of 4. Every load value can then be tried against every enable pattern, which gives an exhaustive sweep of 16 values by 8 control patterns. The bench also chains two stages, so a free-running count passes both the nibble carry and the full 8-bit wrap within a few hundred cycles. A reference model computed in the bench checks both stages after every edge. Further checks look between edges: the clear acting with no clock edge, and the flag following the carry enable with no clock edge.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

  // Action applied at the next rising edge (clear is handled asynchronously)
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_COUNT = 2'd2
  } op_e;

  // Priority: load over counting; counting needs both enables
  function automatic op_e pick_op(input logic load_n, input logic en_a, input logic en_b);
    if (!load_n)         return OP_LOAD;
    else if (en_a && en_b) return OP_COUNT;
    else                 return OP_HOLD;
  endfunction

endpackage

// File: rtl/cnt_op_decode.sv
module cnt_op_decode
  import cnt_pkg::*;
(
  input  logic load_n,
  input  logic en_par,
  input  logic en_carry,
  output op_e  op,
  output logic advance
);

  always_comb begin
    op      = pick_op(load_n, en_par, en_carry);
    advance = (op == OP_COUNT);
  end

endmodule

// File: rtl/cnt_next_value.sv
module cnt_next_value
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  op_e              op,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] nxt,
  output logic             wraps
);

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  function automatic logic [WIDTH-1:0] inc_wrap(input logic [WIDTH-1:0] v);
    return v + {{(WIDTH-1){1'b0}}, 1'b1};
  endfunction

  always_comb begin
    unique case (op)
      OP_LOAD:  nxt = din;
      OP_COUNT: nxt = inc_wrap(cur);
      default:  nxt = cur;
    endcase
    wraps = (op == OP_COUNT) && (cur == ALL_ONES);
  end

endmodule

// File: rtl/cnt_state_reg.sv
module cnt_state_reg
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr_n,
  input  op_e              op,
  input  logic             wraps,
  input  logic [WIDTH-1:0] din,
  input  logic [WIDTH-1:0] nxt,
  output logic [WIDTH-1:0] q
);

  localparam logic [WIDTH-1:0] ZERO = '0;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= ZERO;
    else        q <= nxt;
  end

  // R1: clear holds the count at zero
  p_clear_zero_r1: assert property (@(posedge clk) !clr_n |-> q == ZERO)
    else $error("p_clear_zero_r1");

  // R2: load copies the data word
  p_load_copies_r2: assert property (@(posedge clk) disable iff (!clr_n)
    op == OP_LOAD |=> q == $past(din))
    else $error("p_load_copies_r2");

  // R3: count advances by one
  p_count_inc_r3: assert property (@(posedge clk) disable iff (!clr_n)
    op == OP_COUNT |=> q == WIDTH'($past(q) + 1'b1))
    else $error("p_count_inc_r3");

  // R4: hold keeps the count
  p_hold_stable_r4: assert property (@(posedge clk) disable iff (!clr_n)
    op == OP_HOLD |=> $stable(q))
    else $error("p_hold_stable_r4");

  // R7: wrap lands on zero
  p_wrap_zero_r7: assert property (@(posedge clk) disable iff (!clr_n)
    wraps |=> q == ZERO)
    else $error("p_wrap_zero_r7");

endmodule

// File: rtl/cnt_term_detect.sv
module cnt_term_detect #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic             en_carry,
  output logic             at_max,
  output logic             tc
);

  always_comb begin
    at_max = &q;
    tc     = en_carry & at_max;
  end

endmodule

// File: rtl/casc_counter.sv
module casc_counter
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             en_par,
  input  logic             en_carry,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] count,
  output logic             tc
);

  op_e              op;
  logic             advance;
  logic             wraps;
  logic             at_max;
  logic [WIDTH-1:0] nxt;

  cnt_op_decode u_dec (
    .load_n   (load_n),
    .en_par   (en_par),
    .en_carry (en_carry),
    .op       (op),
    .advance  (advance)
  );

  cnt_next_value #(.WIDTH(WIDTH)) u_nxt (
    .op    (op),
    .cur   (count),
    .din   (din),
    .nxt   (nxt),
    .wraps (wraps)
  );

  cnt_state_reg #(.WIDTH(WIDTH)) u_reg (
    .clk   (clk),
    .clr_n (clr_n),
    .op    (op),
    .wraps (wraps),
    .din   (din),
    .nxt   (nxt),
    .q     (count)
  );

  cnt_term_detect #(.WIDTH(WIDTH)) u_tc (
    .q        (count),
    .en_carry (en_carry),
    .at_max   (at_max),
    .tc       (tc)
  );

  // R5: the flag needs the carry enable and a full count
  p_tc_needs_carry_r5: assert property (@(posedge clk) disable iff (!clr_n)
    tc |-> (en_carry && count == {WIDTH{1'b1}}))
    else $error("p_tc_needs_carry_r5");

  // R3: advancing requires load idle and both enables
  p_adv_gating_r3: assert property (@(posedge clk) disable iff (!clr_n)
    advance |-> (load_n && en_par && en_carry))
    else $error("p_adv_gating_r3");

  // R9: an advancing stage at full count raises the carry for its neighbour
  p_carry_out_r9: assert property (@(posedge clk) disable iff (!clr_n)
    (advance && at_max) |-> tc)
    else $error("p_carry_out_r9");

endmodule

// File: tb/tb_casc_counter.sv
`timescale 1ns/1ps
module tb_casc_counter;

  localparam int W = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         clr_n, load_n, en_par, en_carry;
  logic [W-1:0] din_lo, din_hi;
  logic [W-1:0] q_lo, q_hi;
  logic         tc_lo, tc_hi;

  casc_counter #(.WIDTH(W)) dut (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_par(en_par),
    .en_carry(en_carry), .din(din_lo), .count(q_lo), .tc(tc_lo)
  );

  casc_counter #(.WIDTH(W)) dut_hi (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_par(en_par),
    .en_carry(tc_lo), .din(din_hi), .count(q_hi), .tc(tc_hi)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int m_lo = 0;
  int m_hi = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Model of one edge for both stages, from the requirements
  task automatic model_edge();
    int lo_full;
    lo_full = (en_carry && m_lo == 15) ? 1 : 0;
    if (!load_n) begin
      m_lo = int'(din_lo);
      m_hi = int'(din_hi);
    end else if (en_par) begin
      if (en_carry) m_lo = (m_lo + 1) % 16;
      if (lo_full == 1) m_hi = (m_hi + 1) % 16;
    end
  endtask

  task automatic step(input logic ld, input logic ep, input logic et,
                      input logic [W-1:0] dl, input logic [W-1:0] dh, input string tag);
    load_n = ld; en_par = ep; en_carry = et; din_lo = dl; din_hi = dh;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk({tag, " lo count"}, int'(q_lo), m_lo);
    chk({tag, " hi count"}, int'(q_hi), m_hi);
    chk({"R5 ", tag, " tc"}, int'(tc_lo), (en_carry && m_lo == 15) ? 1 : 0);
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    clr_n = 1'b0; load_n = 1'b1; en_par = 1'b1; en_carry = 1'b1;
    din_lo = '0; din_hi = '0;
    @(negedge clk);
    chk("R1 reset count", int'(q_lo), 0);
    chk("R5 reset tc", int'(tc_lo), 0);
    @(negedge clk);
    chk("R1 clock during clear", int'(q_lo), 0);

    // R8: first edge after release counts normally
    clr_n = 1'b1;
    step(1'b1, 1'b1, 1'b1, 4'd0, 4'd0, "R8 resume");

    // R2/R3/R4: every load value against every enable pattern
    for (int v = 0; v < 16; v++) begin
      for (int c = 0; c < 8; c++) begin
        step(1'b0, 1'b0, 1'b0, 4'(v), 4'(15 - v), "R2 preload");
        if (c[2] == 1'b0)
          step(1'b0, c[1], c[0], 4'(15 - v), 4'(v), "R2 load over enables");
        else if (c[1] && c[0])
          step(1'b1, 1'b1, 1'b1, 4'd0, 4'd0, "R3 count");
        else
          step(1'b1, c[1], c[0], 4'(~v), 4'd0, "R4 hold");
      end
    end

    // Sequence 12,13,14,15,0,1,2 then hold
    step(1'b0, 1'b1, 1'b1, 4'd12, 4'd0, "R2 load twelve");
    for (int k = 0; k < 6; k++) step(1'b1, 1'b1, 1'b1, 4'd0, 4'd0, "R7 wrap sequence");
    chk("R7 value after wrap", int'(q_lo), 2);
    step(1'b1, 1'b0, 1'b1, 4'd0, 4'd0, "R4 inhibit par");
    step(1'b1, 1'b1, 1'b0, 4'd0, 4'd0, "R4 inhibit carry");

    // R6: flag follows carry enable between edges
    step(1'b0, 1'b0, 1'b0, 4'd15, 4'd0, "R2 load fifteen");
    chk("R6 tc with carry low", int'(tc_lo), 0);
    en_carry = 1'b1;
    #0.5;
    chk("R6 tc rises without edge", int'(tc_lo), 1);
    en_carry = 1'b0;
    #0.5;
    chk("R6 tc falls without edge", int'(tc_lo), 0);
    en_carry = 1'b1;
    #0.5;

    // R1: clear mid-period with flag high
    clr_n = 1'b0;
    #0.5;
    chk("R1 async clear count", int'(q_lo), 0);
    chk("R5 tc low in clear", int'(tc_lo), 0);
    chk("R1 async clear hi", int'(q_hi), 0);
    m_lo = 0; m_hi = 0;
    @(negedge clk);
    clr_n = 1'b1;
    step(1'b1, 1'b1, 1'b1, 4'd0, 4'd0, "R8 resume after mid clear");
    chk("R8 count one", int'(q_lo), 1);

    // R9: 8-bit chained run through 0x0F->0x10 and 0xFF->0x00
    step(1'b0, 1'b1, 1'b1, 4'd14, 4'd0, "R9 load 0x0E");
    step(1'b1, 1'b1, 1'b1, 4'd0, 4'd0, "R9 to 0x0F");
    step(1'b1, 1'b1, 1'b1, 4'd0, 4'd0, "R9 to 0x10");
    chk("R9 carry into high nibble", int'(q_hi) * 16 + int'(q_lo), 16);
    step(1'b0, 1'b1, 1'b1, 4'd13, 4'd15, "R9 load 0xFD");
    for (int k = 0; k < 3; k++) step(1'b1, 1'b1, 1'b1, 4'd0, 4'd0, "R9 to wrap");
    chk("R9 full wrap", int'(q_hi) * 16 + int'(q_lo), 0);
    for (int k = 0; k < 300; k++) step(1'b1, 1'b1, 1'b1, 4'd0, 4'd0, "R9 free run");
    chk("R9 free run value", int'(q_hi) * 16 + int'(q_lo), (300 % 256));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule